// File: doc/BRIEF.md
# Dual-Loop Powerdown Controller

This block decides when each of two synthesizer loops enters and leaves powerdown. Each loop has its own set of latched programming bits: a powerdown request and a mode select. It also has a one-cycle strobe that marks the moment those bits are latched, and a status flag from its charge pump that reports the pump is idle (tri-stated). Loop 0 is the IF loop and loop 1 is the RF loop. Each loop is handled the same way and independently of the other. The one shared output is the oscillator disable, which asserts only when both loops are down.

Each loop runs a three-state machine with the states `ST_ACTIVE`, `ST_PEND` and `ST_DOWN`.
- Latching a powerdown request with the mode select high is the immediate transition `ACTIVE->DOWN` or `PEND->DOWN`.
- Latching a request with the mode select low is the gated transition `ACTIVE->PEND`.
- The loop then takes `PEND->DOWN` on the first clock edge at which its charge pump reports idle.
- Latching the powerdown bit low is the release transition `PEND->ACTIVE` or `DOWN->ACTIVE`. In the `DOWN` case it is the wake.

Strobes are accepted in every state, so programming continues while a loop is down. With the powerdown bit low and the select bit high, the loop stays active but its charge pump is held tri-stated.

Top module: `dual_loop_pd_ctrl`

## Requirements
- R1: After reset, every loop is active: `loop_down`, `div_load`, `ref_hiz` and `cp_tri_hold` are all 0, and `osc_off` is 0.
- R2: If a loop's strobe is high with `lat_pd`=1 and `lat_tsel`=1, that loop's `loop_down` is 1 from the next clock edge onward.
- R3: If a loop's strobe is high with `lat_pd`=1 and `lat_tsel`=0, the loop stays active and enters the pending state. `loop_down` rises at the first clock edge at which that loop's `cp_idle` is sampled 1. This is one edge after the strobe at the earliest.
- R4: A pending loop that latches `lat_pd`=0 returns to active. A later `cp_idle`=1 then does not power it down.
- R5: A loop that latches `lat_pd`=0 while down has `loop_down`=0 from the next edge, whatever the value of `lat_tsel`.
- R6: `cp_tri_hold` of a loop equals the `lat_tsel` value from its most recent strobe. With `lat_pd`=0 and `lat_tsel`=1 the loop stays active (`loop_down`=0) while `cp_tri_hold`=1.
- R7: `div_load` and `ref_hiz` of a loop are 1 exactly when its `loop_down` is 1.
- R8: `osc_off` is 1 only when both loops are down. It is 0 when either loop is active or pending.
- R9: While a loop is down it still accepts strobes. A strobe with `lat_pd`=1 keeps the loop down and updates `cp_tri_hold`. A strobe on one loop never changes the other loop's outputs.
- R10: A pending loop that latches `lat_pd`=1 with `lat_tsel`=1 is down from the next edge, without waiting for `cp_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lat_stb | input | 2 | Per-loop one-cycle latch event (bit 0 IF, bit 1 RF) |
| lat_pd | input | 2 | Per-loop powerdown bit, valid with its strobe |
| lat_tsel | input | 2 | Per-loop mode / tri-state select bit, valid with its strobe |
| cp_idle | input | 2 | Per-loop charge pump idle (tri-stated) status |
| loop_down | output | 2 | Per-loop powered-down flag |
| div_load | output | 2 | Per-loop force of the reference and main dividers to the load state |
| ref_hiz | output | 2 | Per-loop reference input debias (high impedance) enable |
| cp_tri_hold | output | 2 | Per-loop hold of the charge pump in tri-state |
| osc_off | output | 1 | Shared oscillator disable |

## Verification
The assertions assume that `lat_pd` and `lat_tsel` matter only in a cycle where the matching strobe bit is high. They also assume that `cp_idle` may change in any cycle, including while a loop is active or already down. The bench drives each strobe high for exactly one cycle, with both data bits set up in the same cycle, and toggles `cp_idle` freely around the pending window. This keeps the stimulus inside those assumptions while still reaching the cancel, override and idle-before-request orderings.

// File: rtl/pd_ctrl_pkg.sv
package pd_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_PEND   = 2'd1,
        ST_DOWN   = 2'd2
    } pd_state_e;

endpackage

// File: rtl/pd_loop_fsm.sv
module pd_loop_fsm
    import pd_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic pd_bit,
    input  logic tsel_bit,
    input  logic cp_idle,
    output logic down,
    output logic div_load,
    output logic ref_hiz,
    output logic cp_tri_hold
);

    pd_state_e state_q, state_d;
    logic      tsel_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (stb && pd_bit)
                    state_d = tsel_bit ? ST_DOWN : ST_PEND;
            end
            ST_PEND: begin
                if (stb && !pd_bit)
                    state_d = ST_ACTIVE;
                else if (stb && pd_bit && tsel_bit)
                    state_d = ST_DOWN;
                else if (cp_idle)
                    state_d = ST_DOWN;
            end
            ST_DOWN: begin
                if (stb && !pd_bit)
                    state_d = ST_ACTIVE;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    // state and latched select register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            tsel_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (stb)
                tsel_q <= tsel_bit;
        end
    end

    // outputs decoded from state
    always_comb begin
        down        = 1'b0;
        div_load    = 1'b0;
        ref_hiz     = 1'b0;
        cp_tri_hold = tsel_q;
        unique case (state_q)
            ST_ACTIVE: ;
            ST_PEND:   ;
            ST_DOWN: begin
                down     = 1'b1;
                div_load = 1'b1;
                ref_hiz  = 1'b1;
            end
            default: ;
        endcase
    end

    // immediate entry (R2)
    p_async_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && pd_bit && tsel_bit) |=> down);

    // gated entry never completes on the strobe edge from active (R3)
    p_sync_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!down && state_q == ST_ACTIVE && stb && pd_bit && !tsel_bit) |=> !down);

    // any rise of down is explained by an immediate request or an idle pump (R3)
    p_down_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!down && (state_q == ST_PEND) && !cp_idle && !(stb && pd_bit && tsel_bit)) |=> !down);

    // release always takes effect on the next edge (R4, R5)
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !pd_bit) |=> (!down && state_q == ST_ACTIVE));

    // strobes with pd high never wake a down loop (R9)
    p_stay_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (down && !(stb && !pd_bit)) |=> down);

endmodule

// File: rtl/pd_osc_gate.sv
module pd_osc_gate #(
    parameter int N_LOOPS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LOOPS-1:0] loops_down,
    output logic               osc_off
);

    assign osc_off = &loops_down;

    // oscillator off implies no loop is awake (R8)
    p_osc_all_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        osc_off |-> ($countones(loops_down) == N_LOOPS));

endmodule

// File: rtl/dual_loop_pd_ctrl.sv
module dual_loop_pd_ctrl #(
    parameter int N_LOOPS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LOOPS-1:0] lat_stb,
    input  logic [N_LOOPS-1:0] lat_pd,
    input  logic [N_LOOPS-1:0] lat_tsel,
    input  logic [N_LOOPS-1:0] cp_idle,
    output logic [N_LOOPS-1:0] loop_down,
    output logic [N_LOOPS-1:0] div_load,
    output logic [N_LOOPS-1:0] ref_hiz,
    output logic [N_LOOPS-1:0] cp_tri_hold,
    output logic               osc_off
);

    for (genvar g = 0; g < N_LOOPS; g++) begin : g_loop
        pd_loop_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .stb        (lat_stb[g]),
            .pd_bit     (lat_pd[g]),
            .tsel_bit   (lat_tsel[g]),
            .cp_idle    (cp_idle[g]),
            .down       (loop_down[g]),
            .div_load   (div_load[g]),
            .ref_hiz    (ref_hiz[g]),
            .cp_tri_hold(cp_tri_hold[g])
        );

        // divider force and debias track powerdown (R7)
        p_side_effects_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (div_load[g] == loop_down[g]) && (ref_hiz[g] == loop_down[g]));
    end

    pd_osc_gate #(.N_LOOPS(N_LOOPS)) u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .loops_down(loop_down),
        .osc_off   (osc_off)
    );

endmodule

// File: tb/tb_dual_loop_pd_ctrl.sv
module tb_dual_loop_pd_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lat_stb = '0;
    logic [1:0] lat_pd = '0;
    logic [1:0] lat_tsel = '0;
    logic [1:0] cp_idle = '0;
    logic [1:0] loop_down, div_load, ref_hiz, cp_tri_hold;
    logic       osc_off;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    dual_loop_pd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .lat_stb(lat_stb), .lat_pd(lat_pd),
        .lat_tsel(lat_tsel), .cp_idle(cp_idle), .loop_down(loop_down),
        .div_load(div_load), .ref_hiz(ref_hiz), .cp_tri_hold(cp_tri_hold),
        .osc_off(osc_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one-cycle strobe on loop l, driven at negedge; returns at the following negedge
    task automatic latch(input int l, input logic pd, input logic ts);
        lat_stb[l]  = 1'b1;
        lat_pd[l]   = pd;
        lat_tsel[l] = ts;
        @(negedge clk);
        lat_stb = '0;
        lat_pd  = '0;
        lat_tsel = '0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        lat_stb = '0; cp_idle = '0;
        idle_cycles(2);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 loop_down", loop_down, 2'b00);
        check("R1 div_load/ref_hiz", {div_load, ref_hiz}, 4'b0000);
        check("R1 cp_tri_hold", cp_tri_hold, 2'b00);
        check("R1 osc_off", osc_off, 1'b0);
    endtask

    task automatic t_async();
        do_reset();
        latch(1, 1'b1, 1'b1);
        check("R2 RF down next edge", loop_down, 2'b10);
        check("R7 side effects", {div_load, ref_hiz}, 4'b1010);
        check("R8 one loop down", osc_off, 1'b0);
        latch(0, 1'b1, 1'b1);
        check("R8 both down", osc_off, 1'b1);
        latch(1, 1'b0, 1'b1);
        check("R5 wake tsel=1", loop_down, 2'b01);
        check("R8 osc back on", osc_off, 1'b0);
    endtask

    task automatic t_sync();
        do_reset();
        latch(0, 1'b1, 1'b0);
        check("R3 pending not down", loop_down, 2'b00);
        idle_cycles(3);
        check("R3 waits for idle", loop_down, 2'b00);
        cp_idle[0] = 1'b1;
        @(negedge clk);
        check("R3 down after idle", loop_down, 2'b01);
        cp_idle[0] = 1'b0;
        idle_cycles(2);
        check("R9 stays down after idle drops", loop_down, 2'b01);
        latch(0, 1'b0, 1'b0);
        check("R5 wake tsel=0", loop_down, 2'b00);
        // idle already high when the request is latched
        cp_idle[1] = 1'b1;
        latch(1, 1'b1, 1'b0);
        check("R3 not on strobe edge", loop_down, 2'b00);
        @(negedge clk);
        check("R3 one edge later", loop_down, 2'b10);
    endtask

    task automatic t_cancel();
        do_reset();
        latch(0, 1'b1, 1'b0);
        idle_cycles(1);
        latch(0, 1'b0, 1'b0);
        cp_idle[0] = 1'b1;
        idle_cycles(3);
        check("R4 cancelled stays active", loop_down, 2'b00);
        cp_idle[0] = 1'b0;
        latch(1, 1'b1, 1'b0);
        latch(1, 1'b1, 1'b1);
        check("R10 override pending", loop_down, 2'b10);
    endtask

    task automatic t_tristate_hold();
        do_reset();
        latch(0, 1'b0, 1'b1);
        check("R6 active with hold", loop_down, 2'b00);
        check("R6 hold set", cp_tri_hold, 2'b01);
        latch(0, 1'b0, 1'b0);
        check("R6 hold cleared", cp_tri_hold, 2'b00);
    endtask

    task automatic t_program_while_down();
        do_reset();
        latch(0, 1'b1, 1'b1);
        latch(1, 1'b0, 1'b1);
        check("R9 other loop untouched", loop_down, 2'b01);
        latch(0, 1'b1, 1'b0);
        check("R9 still down", loop_down, 2'b01);
        check("R9 select updated", cp_tri_hold, 2'b10);
        cp_idle = 2'b11;
        idle_cycles(2);
        check("R9 idle ignored while down", loop_down, 2'b01);
    endtask

    initial begin : watchdog
        #(20 * 5000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_async();
        t_sync();
        t_cancel();
        t_tristate_hold();
        t_program_while_down();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule